// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a 32-bit processor that retires exactly one instruction per clock edge. It handles register-to-register arithmetic and logic (add, sub, and, or, set-on-less-than), word loads and stores, equality branches and absolute jumps. One combinational path per cycle covers every step: fetch, decode, register read, ALU, data memory access and write-back.

The instruction memory and the data memory are internal word arrays. The environment fills them through a load port. While that port is active, execution is frozen. A third read port on the register file lets the environment observe any register at any time. Instruction words use fixed fields. The opcode is bits 31:26, the first source register is 25:21 and the second source or load destination is 20:16. The R-type destination is 15:11 and the R-type function code is 5:0. The 16-bit immediate is 15:0.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears all 32 registers. While reset is high, no register or data memory write takes place.
- R2: An instruction that is neither a taken branch nor a jump advances the PC by 4. The PC always stays word aligned.
- R3: Opcode 000000 is R-type. The function code selects the operation: 100000 add, 100010 subtract, 100100 bitwise and, 100101 bitwise or, 101010 signed set-on-less-than (result 1 or 0). Register rs is the first operand, rt is the second, and the result goes to rd.
- R4: Register 0 always reads as zero. A write to it has no effect.
- R5: Opcode 100011 loads a word into rt. The address is rs plus the sign-extended immediate. Memories are word addressed with address bits [MA_W+1:2], and negative offsets work.
- R6: Opcode 101011 stores rt to the word at rs plus the sign-extended immediate. No register changes.
- R7: Opcode 000100 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it is PC+4.
- R8: Opcode 000010 sets the next PC to the upper 4 bits of PC+4, followed by the 26-bit target field and two zero bits.
- R9: Any other opcode writes no register and no memory, and only advances the PC by 4.
- R10: While load_en is high, the word on load_data is written into data memory (load_to_dmem=1) or instruction memory (load_to_dmem=0) at word index load_idx. The PC holds, and no register or data memory write from execution happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Memory preload strobe; freezes execution while high |
| load_to_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| load_idx | input | MA_W | Word index of the preload write |
| load_data | input | 32 | Word written by the preload |
| dbg_reg | input | 5 | Register number for the observation port |
| dbg_val | output | 32 | Current value of register dbg_reg (0 for register 0) |
| pc_out | output | 32 | Current program counter |

## Verification
Several properties are checked on every cycle:
- the PC is zero once reset is released;
- a sequential instruction advances the PC by exactly 4, and the PC stays aligned;
- a jump lands on the concatenated target;
- a preload holds the PC and suppresses every execution write;
- an undefined opcode writes nothing;
- only a store opcode writes data memory;
- register 0 reads zero.

The data-dependent results cannot be expressed as simple properties: ALU results, load addressing with negative offsets, store-then-load round trips and branch-taken versus not-taken decisions. They are shown by the bench's program. A behavioural model there follows every instruction, and its PC is compared on each clock.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;
  localparam int NREG = 32;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_sel_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       branch;
    logic       jump;
    logic [1:0] alu_class;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc4,
                                                  input logic [15:0] off);
    return pc4 + (sext16(off) << 2);
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc4,
                                                input logic [25:0] tgt);
    return {pc4[XLEN-1:XLEN-4], tgt, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_sel_e sel,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (sel)
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SUB: return a - b;
      ALU_SLT: return ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: return a + b;
    endcase
  endfunction

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_sel_e   alu_sel
);

  always_comb begin
    ctrl = '0;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.alu_class = 2'b10;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_write   = 1'b1;
        ctrl.mem_read    = 1'b1;
        ctrl.alu_class   = 2'b00;
      end
      OPC_STORE: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.mem_write = 1'b1;
        ctrl.alu_class = 2'b00;
      end
      OPC_BEQ: begin
        ctrl.branch    = 1'b1;
        ctrl.alu_class = 2'b01;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end

  always_comb begin
    case (ctrl.alu_class)
      2'b01: alu_sel = ALU_SUB;
      2'b10: begin
        case (funct)
          FN_SUB:  alu_sel = ALU_SUB;
          FN_AND:  alu_sel = ALU_AND;
          FN_OR:   alu_sel = ALU_OR;
          FN_SLT:  alu_sel = ALU_SLT;
          default: alu_sel = ALU_ADD;
        endcase
      end
      default: alu_sel = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  parameter int NRP   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NRP-1:0][$clog2(NREGS)-1:0] rd_addr,
  output logic [NRP-1:0][WIDTH-1:0]     rd_data,
  input  logic                          wr_en,
  input  logic [$clog2(NREGS)-1:0]      wr_addr,
  input  logic [WIDTH-1:0]              wr_data
);

  localparam int AW = $clog2(NREGS);

  logic [WIDTH-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en && (wr_addr != '0)) begin
      regs[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    assign rd_data[p] = (rd_addr[p] == AW'(0)) ? '0 : regs[rd_addr[p]];
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_sel_e        sel,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  assign y    = alu_eval(sel, a, b);
  assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int MA_W     = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             load_to_dmem,
  input  logic [MA_W-1:0]  load_idx,
  input  logic [31:0]      load_data,
  input  logic [4:0]       dbg_reg,
  output logic [31:0]      dbg_val,
  output logic [31:0]      pc_out
);

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, instr;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, mem_rdata, wb_val;
  logic [4:0]      wr_addr;
  logic [MA_W-1:0] mem_idx;
  logic            alu_zero, run, reg_we, mem_we, branch_taken;
  ctrl_t           ctrl;
  alu_sel_e        alu_sel;
  logic [2:0][4:0]      rf_raddr;
  logic [2:0][XLEN-1:0] rf_rdata;

  assign instr    = imem[pc_q[MA_W+1:2]];
  assign pc_plus4 = pc_q + 32'd4;

  sc_decoder u_dec (
    .opcode  (instr[31:26]),
    .funct   (instr[5:0]),
    .ctrl    (ctrl),
    .alu_sel (alu_sel)
  );

  assign rf_raddr[0] = instr[25:21];
  assign rf_raddr[1] = instr[20:16];
  assign rf_raddr[2] = dbg_reg;
  assign rs_val      = rf_rdata[0];
  assign rt_val      = rf_rdata[1];
  assign dbg_val     = rf_rdata[2];

  assign run     = !load_en && !rst;
  assign reg_we  = ctrl.reg_write && run;
  assign mem_we  = ctrl.mem_write && run;
  assign wr_addr = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.NREGS(NREG), .WIDTH(XLEN), .NRP(3)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rf_raddr),
    .rd_data (rf_rdata),
    .wr_en   (reg_we),
    .wr_addr (wr_addr),
    .wr_data (wb_val)
  );

  assign imm_ext = sext16(instr[15:0]);
  assign alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;

  sc_alu u_alu (
    .sel  (alu_sel),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign mem_idx   = alu_y[MA_W+1:2];
  assign mem_rdata = ctrl.mem_read ? dmem[mem_idx] : '0;
  assign wb_val    = ctrl.wb_from_mem ? mem_rdata : alu_y;

  assign branch_taken = ctrl.branch && alu_zero;
  assign pc_next = ctrl.jump   ? jump_dest(pc_plus4, instr[25:0]) :
                   branch_taken ? branch_dest(pc_plus4, instr[15:0]) :
                                  pc_plus4;

  always_ff @(posedge clk) begin
    if (rst)      pc_q <= '0;
    else if (run) pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      if (load_to_dmem) dmem[load_idx] <= load_data;
      else              imem[load_idx] <= load_data;
    end else if (mem_we) begin
      dmem[mem_idx] <= rt_val;
    end
  end

  assign pc_out = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        load_en,
  input logic [31:0] pc_q,
  input logic [31:0] instr,
  input logic        reg_we,
  input logic        mem_we,
  input logic [4:0]  dbg_reg,
  input logic [31:0] dbg_val
);

  logic [5:0] op;
  logic       op_known, op_seq;
  assign op       = instr[31:26];
  assign op_known = (op == 6'd0) || (op == 6'd35) || (op == 6'd43) ||
                    (op == 6'd4) || (op == 6'd2);
  assign op_seq   = (op != 6'd4) && (op != 6'd2);

  assert_pc_zero_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc_q == 32'd0);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_en && op_seq) |=> pc_q == $past(pc_q) + 32'd4);

  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (rst)
    dbg_reg == 5'd0 |-> dbg_val == 32'd0);

  assert_store_only_by_sw_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> op == 6'd43);

  assert_jump_dest_R8: assert property (@(posedge clk) disable iff (rst)
    (!load_en && op == 6'd2) |=>
      pc_q == ((($past(pc_q) + 32'd4) & 32'hF000_0000) | {4'b0, $past(instr[25:0]), 2'b00}));

  assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> (!reg_we && !mem_we));

  assert_load_no_exec_write_R10: assert property (@(posedge clk) disable iff (rst)
    load_en |-> (!reg_we && !mem_we));

  assert_load_pc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    load_en |=> $stable(pc_q));

endmodule

bind sc_core sc_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .load_en (load_en),
  .pc_q    (pc_q),
  .instr   (instr),
  .reg_we  (reg_we),
  .mem_we  (mem_we),
  .dbg_reg (dbg_reg),
  .dbg_val (dbg_val)
);

// File: tb/test_sc_core.sv
module test_sc_core;

  localparam int CLK_PERIOD = 10;
  localparam int MW   = 64;
  localparam int MAW  = $clog2(MW);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           load_en = 1'b0;
  logic           load_to_dmem = 1'b0;
  logic [MAW-1:0] load_idx = '0;
  logic [31:0]    load_data = '0;
  logic [4:0]     dbg_reg = '0;
  logic [31:0]    dbg_val, pc_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core #(.MEM_WORDS(MW)) i_sc_core (
    .clk(clk), .rst(rst), .load_en(load_en), .load_to_dmem(load_to_dmem),
    .load_idx(load_idx), .load_data(load_data), .dbg_reg(dbg_reg),
    .dbg_val(dbg_val), .pc_out(pc_out)
  );

  // behavioural reference model
  logic [31:0] m_pc;
  logic [31:0] m_reg [32];
  logic [31:0] m_imem [MW];
  logic [31:0] m_dmem [MW];
  string       m_tag = "R1";

  function automatic logic [31:0] rt_w(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] it_w(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic model_step();
    logic [31:0] w, a, b, r, npc, addr;
    int op, rs, rt, rd, fn;
    w   = m_imem[m_pc[MAW+1:2]];
    op  = int'(w[31:26]); rs = int'(w[25:21]); rt = int'(w[20:16]);
    rd  = int'(w[15:11]); fn = int'(w[5:0]);
    a   = m_reg[rs]; b = m_reg[rt];
    npc = m_pc + 4;
    addr = a + {{16{w[15]}}, w[15:0]};
    case (op)
      0: begin
        case (fn)
          34: r = a - b;
          36: r = a & b;
          37: r = a | b;
          42: r = ($signed(a) < $signed(b)) ? 1 : 0;
          default: r = a + b;
        endcase
        if (rd != 0) m_reg[rd] = r;
        m_tag = "R3";
      end
      35: begin if (rt != 0) m_reg[rt] = m_dmem[addr[MAW+1:2]]; m_tag = "R5"; end
      43: begin m_dmem[addr[MAW+1:2]] = b; m_tag = "R6"; end
      4: begin
        if (a == b) npc = npc + ({{16{w[15]}}, w[15:0]} * 4);
        m_tag = "R7";
      end
      2: begin npc = {npc[31:28], w[25:0], 2'b00}; m_tag = "R8"; end
      default: m_tag = "R9";
    endcase
    m_pc = npc;
  endtask

  always @(posedge clk) begin
    if (load_en) begin
      if (load_to_dmem) m_dmem[load_idx] = load_data;
      else              m_imem[load_idx] = load_data;
    end
    if (rst) begin
      m_pc = 0;
      for (int i = 0; i < 32; i++) m_reg[i] = 0;
      m_tag = "R1";
    end else if (load_en) begin
      m_tag = "R10";
    end else begin
      model_step();
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle PC comparison against the model
  always @(negedge clk) begin
    if (!done) check(pc_out === m_pc, m_tag, pc_out, m_pc);
  end

  task automatic chk_reg(int idx, logic [31:0] exp, string tag);
    dbg_reg = 5'(idx);
    #1;
    check(dbg_val === exp, tag, dbg_val, exp);
    check(dbg_val === m_reg[idx], tag, dbg_val, m_reg[idx]);
  endtask

  task automatic load_word(bit to_d, int idx, logic [31:0] data);
    @(negedge clk);
    load_en = 1'b1; load_to_dmem = to_d; load_idx = MAW'(idx); load_data = data;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // data preload
    load_word(1, 0, 32'd5);
    load_word(1, 1, 32'hFFFF_FFFD);
    load_word(1, 2, 32'h0000_00F0);
    // program
    load_word(0, 0,  it_w(35, 0, 1, 0));        // lw r1,0(r0)
    load_word(0, 1,  it_w(35, 0, 2, 4));        // lw r2,4(r0)
    load_word(0, 2,  rt_w(1, 2, 3, 32));        // add r3
    load_word(0, 3,  rt_w(1, 2, 4, 34));        // sub r4
    load_word(0, 4,  rt_w(1, 2, 5, 36));        // and r5
    load_word(0, 5,  rt_w(1, 2, 6, 37));        // or r6
    load_word(0, 6,  rt_w(2, 1, 7, 42));        // slt r7 = (-3<5)
    load_word(0, 7,  rt_w(1, 2, 8, 42));        // slt r8 = (5<-3)
    load_word(0, 8,  rt_w(1, 1, 0, 32));        // add r0 (ignored)
    load_word(0, 9,  it_w(43, 0, 4, 12));       // sw r4,12(r0)
    load_word(0, 10, it_w(35, 4, 9, 4));        // lw r9,4(r4)
    load_word(0, 11, it_w(35, 4, 10, 16'hFFF8)); // lw r10,-8(r4)
    load_word(0, 12, 32'hFC2D_0000);            // undefined opcode
    load_word(0, 13, it_w(4, 1, 2, 5));         // beq not taken
    load_word(0, 14, it_w(4, 1, 10, 2));        // beq taken -> word 17
    load_word(0, 15, rt_w(1, 1, 11, 32));       // skipped
    load_word(0, 16, rt_w(1, 1, 11, 32));       // skipped
    load_word(0, 17, {6'd2, 26'd20});           // j word 20
    load_word(0, 18, rt_w(1, 1, 12, 32));       // skipped
    load_word(0, 19, rt_w(1, 1, 12, 32));       // skipped
    load_word(0, 20, it_w(4, 0, 0, 16'hFFFF));  // self loop
    @(negedge clk);
    load_en = 1'b0;
    #1;
    check(pc_out === 32'd0, "R1", pc_out, 32'd0);
    chk_reg(3, 32'd0, "R1");
    @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    #1;
    check(pc_out === 32'd80, "R7", pc_out, 32'd80);
    chk_reg(0, 32'd0, "R4");
    chk_reg(1, 32'd5, "R5");
    chk_reg(2, 32'hFFFF_FFFD, "R5");
    chk_reg(3, 32'd2, "R3");
    chk_reg(4, 32'd8, "R3");
    chk_reg(5, 32'd5, "R3");
    chk_reg(6, 32'hFFFF_FFFD, "R3");
    chk_reg(7, 32'd1, "R3");
    chk_reg(8, 32'd0, "R3");
    chk_reg(9, 32'd8, "R6");
    chk_reg(10, 32'd5, "R5");
    chk_reg(11, 32'd0, "R7");
    chk_reg(12, 32'd0, "R8");
    chk_reg(13, 32'd0, "R9");
    // preload while running: PC must freeze
    load_word(0, 40, 32'h1234_5678);
    load_word(0, 41, 32'h9ABC_DEF0);
    load_word(1, 5,  32'h0000_0077);
    @(negedge clk);
    #1;
    check(pc_out === 32'd80, "R10", pc_out, 32'd80);
    chk_reg(9, 32'd8, "R10");
    load_en = 1'b0;
    repeat (3) @(negedge clk);
    // second reset
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(pc_out === 32'd0, "R1", pc_out, 32'd0);
    chk_reg(1, 32'd0, "R1");
    rst = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    check(pc_out === 32'd24, "R2", pc_out, 32'd24);
    chk_reg(4, 32'd8, "R3");
    finish_run();
  end

endmodule